// File: doc/BRIEF.md
# Shift Unit with Status Flags

This combinational unit shifts an operand left, logically right or arithmetically right at a selected width of 8, 16 or 32 bits. In the same evaluation it produces the new carry, overflow, sign, zero and parity flags. The count is a full 8-bit value and is never reduced modulo the width. A count at or beyond the width therefore has its own defined outcome for each operation.

The unit also drives a flag write-enable. It goes low when the operation must leave the destination and the flag register untouched: a count of zero, or the reserved operation code. Instruction decode, the register file and flag storage belong to the caller. Auxiliary carry is not produced, and the caller treats it as undefined.

The block has no clock and no state. Every output follows the inputs within the same cycle. There is no handshake, because the caller registers the result and flags itself.

Top module: `shf_unit`

## Requirements
- R1: With `count_i` zero and a defined operation code, `flags_we_o` is low, `result_o` equals the operand at the selected width, and all five flag outputs are low.
- R2: Left shift (op code 0) with 0 < count < W gives the operand shifted left by count, truncated to W bits. Carry is operand bit W-count. Overflow is operand bit W-count XOR operand bit W-count-1, where bit -1 reads as 0.
- R3: Left shift with count equal to W gives result zero, and both carry and overflow equal operand bit 0.
- R4: Left shift with count greater than W gives result zero, with carry and overflow low.
- R5: Arithmetic right shift (op code 2) with count < W fills the vacated upper bits with operand bit W-1, and carry is operand bit count-1. With count >= W, every result bit and the carry equal operand bit W-1.
- R6: Arithmetic right shift drives overflow low for every non-zero count.
- R7: Logical right shift (op code 1) gives overflow equal to operand bit W-1. For count < W, the result is the operand shifted right with zero fill, and carry is operand bit count-1. For count == W, carry is operand bit W-1 and the result is zero. For count > W, both carry and result are zero.
- R8: For a non-zero count, sign is result bit W-1. Zero is high exactly when the W-bit result is zero. Parity is high when result bits 7..0 hold an even number of ones.
- R9: Size code 0 selects W=8, code 1 selects W=16, and codes 2 and 3 select W=32. Operand bits at W and above are ignored, and result bits at W and above are driven zero.
- R10: Op code 3 is reserved. It drives `flags_we_o` low, `result_o` to the operand at width W, and every flag low, for any count.
- R11: Counts from 33 to 255 are applied unreduced under the rules above, and `flags_we_o` stays high for them on op codes 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation: 0 left, 1 logical right, 2 arithmetic right, 3 reserved |
| size_i | input | 2 | Operand width: 0 byte, 1 halfword, 2 or 3 word |
| count_i | input | 8 | Shift count, unmasked |
| operand_i | input | 32 | Value to shift |
| result_o | output | 32 | Shifted value, zero above the selected width |
| flags_we_o | output | 1 | High when destination and flags are to be written |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| sign_o | output | 1 | New sign flag |
| zero_o | output | 1 | New zero flag |
| parity_o | output | 1 | New parity flag (even ones in low byte) |

## Verification
Two rules can meet in one evaluation: the out-of-range count handling and the per-operation overflow and carry rules. This happens at the count equal to the width and the count one beyond it. There a left shift must take both flags from bit 0, or clear them both, while a logical right shift must still report the original top bit as overflow. The bench provokes this by sweeping every count from 0 to 255 for each operation and width. It uses zero, all-ones, the lone sign bit and random operands with garbage above the width. It judges every output against a model that shifts one bit per loop step.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int LANES  = 3;
  localparam int WID_W  = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_SAR = 2'd2,
    OP_RSV = 2'd3
  } shf_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } shf_size_e;
endpackage

// File: rtl/shf_operand_fmt.sv
module shf_operand_fmt
  import shf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WID_W
) (
  input  logic [1:0]      size_i,
  input  logic [DW-1:0]   raw_i,
  output logic [DW-1:0]   mask_o,
  output logic [DW-1:0]   opnd_o,
  output logic [2*DW-1:0] sext_o,
  output logic [WW-1:0]   width_o,
  output logic            msb_o
);
  localparam int SEL_W = $clog2(LANES);

  logic [DW-1:0]    lane_mask [LANES];
  logic [WW-1:0]    lane_w    [LANES];
  logic [SEL_W-1:0] sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = DW >> (LANES - 1 - g);
    assign lane_w[g] = WW'(LW);
    for (genvar i = 0; i < DW; i++) begin : g_bit
      assign lane_mask[g][i] = (i < LW);
    end
  end

  always_comb begin
    unique case (shf_size_e'(size_i))
      SZ_BYTE: sel = SEL_W'(0);
      SZ_HALF: sel = SEL_W'(1);
      default: sel = SEL_W'(LANES - 1);
    endcase
  end

  assign mask_o  = lane_mask[sel];
  assign width_o = lane_w[sel];
  assign opnd_o  = raw_i & mask_o;
  assign msb_o   = opnd_o[width_o - WW'(1)];
  assign sext_o  = {{DW{msb_o}}, opnd_o | (~mask_o & {DW{msb_o}})};

  always_comb begin
    p_mask_r9: assert ((opnd_o & ~mask_o) == '0);
  end
endmodule

// File: rtl/shf_left.sv
module shf_left
  import shf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int WW = WID_W
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] mask_i,
  input  logic [WW-1:0] width_i,
  input  logic [CW-1:0] count_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o,
  output logic          of_o
);
  logic [DW:0] wide;
  logic [DW:0] diff;
  logic [DW:0] diff_sh;

  // Bit W of the shifted word is the last bit pushed out; zeros fill for big counts.
  assign wide    = {1'b0, opnd_i} << count_i;
  assign diff    = {1'b0, opnd_i} ^ {opnd_i, 1'b0};
  assign diff_sh = diff << count_i;

  assign res_o = wide[DW-1:0] & mask_i;
  assign cf_o  = wide[width_i];
  assign of_o  = diff_sh[width_i];

  always_comb begin
    if (CW'(width_i) == count_i) begin
      p_edge_left_r3: assert (cf_o == opnd_i[0] && of_o == opnd_i[0] && res_o == '0);
    end
  end
endmodule

// File: rtl/shf_right.sv
module shf_right
  import shf_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int CW    = CNT_W,
  parameter int WW    = WID_W,
  parameter bit ARITH = 1'b0
) (
  input  logic [2*DW-1:0] ext_i,
  input  logic [DW-1:0]   mask_i,
  input  logic [WW-1:0]   width_i,
  input  logic [CW-1:0]   count_i,
  output logic [DW-1:0]   res_o,
  output logic            cf_o
);
  logic [DW:0] v;

  if (ARITH) begin : g_arith
    logic signed [2*DW:0] src;
    assign src = $signed({ext_i, 1'b0});
    assign v   = (DW+1)'(src >>> count_i);
  end else begin : g_logic
    assign v = (DW+1)'({ext_i, 1'b0} >> count_i);
  end

  assign res_o = v[DW:1] & mask_i;
  assign cf_o  = v[0];

  always_comb begin
    if (ARITH && count_i >= CW'(width_i)) begin
      p_fill_r5: assert ((res_o == mask_i || res_o == '0) && cf_o == res_o[0]);
    end
  end
endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
  import shf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WID_W
) (
  input  logic [DW-1:0] res_i,
  input  logic [WW-1:0] width_i,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o
);
  assign sf_o = res_i[width_i - WW'(1)];
  assign zf_o = ~|res_i;
  assign pf_o = ~^res_i[7:0];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flags_we_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              sign_o,
  output logic              zero_o,
  output logic              parity_o
);
  localparam int NRIGHT = 2;

  logic [DATA_W-1:0]   mask, opnd;
  logic [2*DATA_W-1:0] sext;
  logic [WID_W-1:0]    width;
  logic                msb;

  logic [DATA_W-1:0] l_res;
  logic              l_cf, l_of;
  logic [DATA_W-1:0] r_res [NRIGHT];
  logic              r_cf  [NRIGHT];

  logic [DATA_W-1:0] sel_res;
  logic              sel_cf, sel_of, act;
  logic              f_sf, f_zf, f_pf;

  shf_operand_fmt #(.DW(DATA_W), .WW(WID_W)) u_fmt (
    .size_i (size_i),
    .raw_i  (operand_i),
    .mask_o (mask),
    .opnd_o (opnd),
    .sext_o (sext),
    .width_o(width),
    .msb_o  (msb)
  );

  shf_left #(.DW(DATA_W), .CW(CNT_W), .WW(WID_W)) u_left (
    .opnd_i (opnd),
    .mask_i (mask),
    .width_i(width),
    .count_i(count_i),
    .res_o  (l_res),
    .cf_o   (l_cf),
    .of_o   (l_of)
  );

  // Index 0: zero fill, index 1: sign fill.
  for (genvar g = 0; g < NRIGHT; g++) begin : g_right
    localparam bit ARITH = (g == 1);
    shf_right #(.DW(DATA_W), .CW(CNT_W), .WW(WID_W), .ARITH(ARITH)) u_right (
      .ext_i  (ARITH ? sext : {{DATA_W{1'b0}}, opnd}),
      .mask_i (mask),
      .width_i(width),
      .count_i(count_i),
      .res_o  (r_res[g]),
      .cf_o   (r_cf[g])
    );
  end

  always_comb begin
    unique case (shf_op_e'(op_i))
      OP_SHL:  begin sel_res = l_res;    sel_cf = l_cf;    sel_of = l_of; end
      OP_SHR:  begin sel_res = r_res[0]; sel_cf = r_cf[0]; sel_of = msb;  end
      OP_SAR:  begin sel_res = r_res[1]; sel_cf = r_cf[1]; sel_of = 1'b0; end
      default: begin sel_res = opnd;     sel_cf = 1'b0;    sel_of = 1'b0; end
    endcase
  end

  shf_flag_gen #(.DW(DATA_W), .WW(WID_W)) u_flags (
    .res_i  (sel_res),
    .width_i(width),
    .sf_o   (f_sf),
    .zf_o   (f_zf),
    .pf_o   (f_pf)
  );

  assign act        = (count_i != '0) && (shf_op_e'(op_i) != OP_RSV);
  assign flags_we_o = act;
  assign result_o   = act ? sel_res : opnd;
  assign carry_o    = act & sel_cf;
  assign ovf_o      = act & sel_of;
  assign sign_o     = act & f_sf;
  assign zero_o     = act & f_zf;
  assign parity_o   = act & f_pf;

  always_comb begin
    if (count_i == '0) begin
      p_quiet_r1: assert (!flags_we_o && result_o == (operand_i & mask));
    end
    if (shf_op_e'(op_i) == OP_SAR) begin
      p_no_overflow_r6: assert (!ovf_o);
    end
    if (shf_op_e'(op_i) == OP_SHL && int'(count_i) > int'(width)) begin
      p_wide_left_r4: assert (result_o == '0 && !carry_o && !ovf_o);
    end
    p_high_clear_r9: assert ((result_o & ~mask) == '0);
    if (flags_we_o && zero_o) begin
      p_zero_even_r8: assert (!sign_o && parity_o);
    end
  end
endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [1:0]  op, sz;
  logic [7:0]  cnt;
  logic [31:0] opr;
  logic [31:0] res;
  logic        we, cf, of, sf, zf, pf;

  int n_chk = 0;
  int n_bad = 0;

  shf_unit uut (
    .op_i(op), .size_i(sz), .count_i(cnt), .operand_i(opr),
    .result_o(res), .flags_we_o(we), .carry_o(cf), .ovf_o(of),
    .sign_o(sf), .zero_o(zf), .parity_o(pf)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s op=%0d size=%0d count=%0d operand=%h: actual %h expected %h",
               tag, what, op, sz, cnt, opr, act, exp);
    end
  endtask

  function automatic int width_of(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : 32;
  endfunction

  // Bit-at-a-time reference.
  task automatic model(input int o, input int s, input int c, input logic [31:0] a,
                       output logic [31:0] r, output logic e_we, e_cf, e_of,
                       output logic e_sf, e_zf, e_pf);
    int w;
    logic [31:0] m, v, p;
    logic sg;
    w = width_of(s);
    m = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    v = a & m;
    r = v; e_we = 0; e_cf = 0; e_of = 0; e_sf = 0; e_zf = 0; e_pf = 0;
    if (o == 3 || c == 0) return;
    e_we = 1;
    sg = v[w-1];
    p = v;
    for (int i = 0; i < c; i++) begin
      p = v;
      case (o)
        0: begin e_cf = v[w-1]; v = (v << 1) & m; end
        1: begin e_cf = v[0];   v = v >> 1; end
        default: begin e_cf = v[0]; v = (v >> 1) | (sg ? (32'd1 << (w-1)) : 32'd0); end
      endcase
    end
    case (o)
      0: e_of = p[w-1] ^ p[w-2];
      1: e_of = sg;
      default: e_of = 1'b0;
    endcase
    r = v;
    e_sf = v[w-1];
    e_zf = (v == 32'd0);
    e_pf = ~^v[7:0];
  endtask

  function automatic string tag_of(input int o, input int s, input int c);
    int w;
    w = width_of(s);
    if (o == 3) return "R10";
    if (c == 0) return "R1";
    if (o == 0) return (c < w) ? "R2" : (c == w) ? "R3" : "R4";
    if (o == 2) return "R5";
    return "R7";
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] e_r, m;
    logic e_we, e_cf, e_of, e_sf, e_zf, e_pf;
    string t;
    rst_n = 1'b0;
    op = 2'd0; sz = 2'd0; cnt = 8'd0; opr = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rest write enable", {31'd0, we}, 32'd0);
    chk("R1", "rest result", res, 32'd0);
    chk("R1", "rest flags", {27'd0, cf, of, sf, zf, pf}, 32'd0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 6; k++) begin
          for (int c = 0; c < 256; c++) begin
            @(posedge clk);
            op  = 2'(o);
            sz  = 2'(s);
            cnt = 8'(c);
            case (k)
              0: opr = 32'd0;
              1: opr = 32'hffff_ffff;
              2: opr = 32'd1 << (width_of(s) - 1);
              default: opr = $urandom;
            endcase
            @(negedge clk);
            model(o, s, c, opr, e_r, e_we, e_cf, e_of, e_sf, e_zf, e_pf);
            t = tag_of(o, s, c);
            m = (width_of(s) == 32) ? 32'hffff_ffff : ((32'd1 << width_of(s)) - 32'd1);
            chk(t, "result", res, e_r);
            chk(t, "carry", {31'd0, cf}, {31'd0, e_cf});
            chk((o == 2) ? "R6" : t, "overflow", {31'd0, of}, {31'd0, e_of});
            chk(t, "write enable", {31'd0, we}, {31'd0, e_we});
            chk(e_we ? "R8" : t, "sign/zero/parity", {29'd0, sf, zf, pf},
                {29'd0, e_sf, e_zf, e_pf});
            if (s != 2) chk("R9", "bits above width", res & ~m, 32'd0);
            if (c > 32 && o != 3) chk("R11", "unreduced count acted", {31'd0, we}, 32'd1);
          end
        end
      end
    end

    summary();
    $finish;
  end
endmodule